// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets a host processor reach a bank of 16-bit registers over a four-wire serial link. Every transfer is a 16-bit frame that the host clocks out most significant bit first, with the clock idling high. Data is taken in on rising clock edges and put out on falling ones. A frame either requests a register or writes a single byte of one. The read result comes back on the data output during the frame that follows. The host can therefore place its next request in that same frame and keep a continuous stream of reads going.

The serial pins are brought into a fast system clock domain through synchronizers. The register storage itself sits outside the block, behind a simple register bus. That bus has a combinational read port (word address out, data in) and a write port (word address, byte strobes, data). The block also counts the clock edges in every chip-select window. If a window ends partway through a frame, it records the fault in a status word that clears when it is read.

Top module: `spr_spi_regslave`

## Requirements
- R1: A frame is 16 bits, MSB first. Bit 15 is the write flag (1 = write), bits 14:8 are a byte address, and bits 7:0 are the write byte.
- R2: A read request returns the 16-bit register holding that byte address during the next frame. The word goes out MSB first on `miso_o`, which changes after falling SCLK edges.
- R3: `miso_en_o` is high only while `csn_i` is low and the last completed frame was a read request. It is low whenever `csn_i` is high.
- R4: A write to an even byte address asserts `wr_strb_o` = 2'b01 (bits 7:0). A write to an odd byte address asserts 2'b10 (bits 15:8). `wr_addr_o` is the byte address shifted right by one, and the byte appears on both halves of `wr_data_o`. For example, frame 0xA203 writes 0x03 to the low byte of word 0x11.
- R5: Several frames may run back to back in one chip-select window. Each frame returns the result of the request made in the frame before it.
- R6: If a chip-select window ends after a count of rising SCLK edges that is not a multiple of 16, bit 3 of the status word (byte address 0x2E/0x2F) is set. A window of 32 edges leaves it clear.
- R7: Reading the status word returns its current flags and clears them in the same step.
- R8: Writes to byte addresses 0x00–0x07 and to the status word produce no strobe and raise no error.
- R9: Bits 7:0 of a read-request frame have no effect on the data returned.
- R10: After reset, `miso_en_o` and `wr_strb_o` are low and the status word reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host, idles high |
| csn_i | input | 1 | Chip select from host, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_en_o | output | 1 | Output driver enable for `miso_o`; low means high impedance |
| rd_addr_o | output | 6 | Word address of the pending read |
| rd_data_i | input | 16 | Register word for `rd_addr_o`, combinational |
| wr_addr_o | output | 6 | Word address of a write |
| wr_strb_o | output | 2 | Byte strobes of a write, one-cycle pulse |
| wr_data_o | output | 16 | Write byte copied to both halves |

## Verification
A rising SCLK edge reaches the frame logic after the two synchronizer stages and one edge-detect register. The completed frame is then registered once more, so strobes and the read-data load occur about five system cycles after the last rising edge. The bench keeps chip select low for eight cycles after that edge before it looks at the write log. A change of `miso_o` follows a falling SCLK edge by about four cycles, so the bench samples each bit 35 ns after the falling edge and 5 ns before the next rising edge. `miso_en_o` follows `csn_i` with no delay and is checked within the same window.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;
   localparam int ADDR_W  = 7;
   localparam int DATA_W  = 8;
   localparam int FRAME_W = 1 + ADDR_W + DATA_W;
   localparam int REG_W   = 2 * DATA_W;
   localparam int WORD_AW = ADDR_W - 1;
   localparam int STRB_W  = REG_W / DATA_W;

   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] payload;
   } spr_frame_t;
endpackage

// File: rtl/spr_sync.sv
`timescale 1ns/1ps
module spr_sync #(
   parameter int           W       = 3,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spr_shifter.sv
`timescale 1ns/1ps
module spr_shifter
   import spr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               csn_s,
   input  logic               din_s,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] load_data_i,
   output logic               frm_vld_o,
   output logic [FRAME_W-1:0] frm_o,
   output logic               len_err_o,
   output logic               dout_o
);
   localparam int CW = $clog2(FRAME_W);
   localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

   logic               sclk_d, csn_d;
   logic               rise, fall, cs_end;
   logic [CW-1:0]      cnt;
   logic [FRAME_W-2:0] rx_sh;
   logic [FRAME_W-1:0] tx_sh;

   assign rise   =  sclk_s & ~sclk_d & ~csn_s;
   assign fall   = ~sclk_s &  sclk_d & ~csn_s;
   assign cs_end =  csn_s  & ~csn_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b1;
         csn_d     <= 1'b1;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         dout_o    <= 1'b0;
         frm_vld_o <= 1'b0;
         frm_o     <= '0;
         len_err_o <= 1'b0;
      end else begin
         sclk_d    <= sclk_s;
         csn_d     <= csn_s;
         frm_vld_o <= 1'b0;
         len_err_o <= 1'b0;
         if (cs_end) begin
            cnt       <= '0;
            len_err_o <= (cnt != '0);
         end else if (rise) begin
            rx_sh <= {rx_sh[FRAME_W-3:0], din_s};
            if (cnt == LAST) begin
               cnt       <= '0;
               frm_vld_o <= 1'b1;
               frm_o     <= {rx_sh, din_s};
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (load_i) begin
            tx_sh <= load_data_i;
         end else if (fall) begin
            dout_o <= tx_sh[FRAME_W-1];
            tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spr_decode.sv
`timescale 1ns/1ps
module spr_decode
   import spr_pkg::*;
#(
   parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h2E,
   parameter logic [ADDR_W-1:0] RO_LIMIT  = 7'h08,
   parameter int                STAT_BIT  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_vld_i,
   input  spr_frame_t         frm_i,
   input  logic               len_err_i,
   output logic [WORD_AW-1:0] rd_addr_o,
   input  logic [REG_W-1:0]   rd_data_i,
   output logic [WORD_AW-1:0] wr_addr_o,
   output logic [STRB_W-1:0]  wr_strb_o,
   output logic [REG_W-1:0]   wr_data_o,
   output logic               load_o,
   output logic [REG_W-1:0]   load_data_o,
   output logic               pend_o
);
   localparam logic [WORD_AW-1:0] STAT_WORD = STAT_ADDR[ADDR_W-1:1];
   localparam logic [WORD_AW-1:0] RO_WORDS  = RO_LIMIT[ADDR_W-1:1];

   logic [WORD_AW-1:0] word;
   logic               is_stat, ro_range, do_wr;
   logic               err_q, pend_q;

   assign word    = frm_i.addr[ADDR_W-1:1];
   assign is_stat = (word == STAT_WORD);

   generate
      if (RO_LIMIT == '0) begin : g_no_ro
         assign ro_range = 1'b0;
      end else begin : g_ro
         assign ro_range = (word < RO_WORDS);
      end
   endgenerate

   assign do_wr     = frm_vld_i & frm_i.wr & ~ro_range & ~is_stat;
   assign wr_addr_o = word;
   assign wr_strb_o = do_wr ? (frm_i.addr[0] ? 2'b10 : 2'b01) : 2'b00;
   assign wr_data_o = {STRB_W{frm_i.payload}};
   assign rd_addr_o = word;
   assign load_o    = frm_vld_i & ~frm_i.wr;
   assign pend_o    = pend_q;

   always_comb begin
      load_data_o = rd_data_i;
      if (is_stat) begin
         load_data_o           = '0;
         load_data_o[STAT_BIT] = err_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (frm_vld_i)            pend_q <= ~frm_i.wr;
         if (len_err_i)            err_q  <= 1'b1;
         else if (load_o & is_stat) err_q <= 1'b0;
      end
   end
endmodule

// File: rtl/spr_spi_regslave.sv
`timescale 1ns/1ps
module spr_spi_regslave
   import spr_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 7'h2E,
   parameter logic [ADDR_W-1:0] RO_LIMIT    = 7'h08,
   parameter int                STAT_BIT    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_i,
   input  logic               csn_i,
   input  logic               mosi_i,
   output logic               miso_o,
   output logic               miso_en_o,
   output logic [WORD_AW-1:0] rd_addr_o,
   input  logic [REG_W-1:0]   rd_data_i,
   output logic [WORD_AW-1:0] wr_addr_o,
   output logic [STRB_W-1:0]  wr_strb_o,
   output logic [REG_W-1:0]   wr_data_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spr_spi_regslave: SYNC_STAGES must be at least 2");
      end
      if (STAT_BIT >= REG_W) begin : g_bad_bit
         $error("spr_spi_regslave: STAT_BIT outside register word");
      end
      if (STAT_ADDR[0] != 1'b0) begin : g_bad_stat
         $error("spr_spi_regslave: STAT_ADDR must be even");
      end
      if (REG_W != FRAME_W) begin : g_bad_w
         $error("spr_spi_regslave: register word must match frame width");
      end
   endgenerate

   logic [2:0]         sync_q;
   logic               frm_vld, len_err, load, dout, pend;
   logic [FRAME_W-1:0] frm_bits, load_data;
   spr_frame_t         frm_st;

   spr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sclk_i, csn_i, mosi_i}),
      .q_o   (sync_q)
   );

   spr_shifter i_shifter (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s      (sync_q[2]),
      .csn_s       (sync_q[1]),
      .din_s       (sync_q[0]),
      .load_i      (load),
      .load_data_i (load_data),
      .frm_vld_o   (frm_vld),
      .frm_o       (frm_bits),
      .len_err_o   (len_err),
      .dout_o      (dout)
   );

   assign frm_st = frm_bits;

   spr_decode #(.STAT_ADDR(STAT_ADDR), .RO_LIMIT(RO_LIMIT), .STAT_BIT(STAT_BIT)) i_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .frm_vld_i   (frm_vld),
      .frm_i       (frm_st),
      .len_err_i   (len_err),
      .rd_addr_o   (rd_addr_o),
      .rd_data_i   (rd_data_i),
      .wr_addr_o   (wr_addr_o),
      .wr_strb_o   (wr_strb_o),
      .wr_data_o   (wr_data_o),
      .load_o      (load),
      .load_data_o (load_data),
      .pend_o      (pend)
   );

   assign miso_o    = dout;
   assign miso_en_o = ~csn_i & pend;
endmodule

// File: rtl/spr_spi_regslave_chk.sv
`timescale 1ns/1ps
module spr_spi_regslave_chk
   import spr_pkg::*;
#(
   parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h2E,
   parameter logic [ADDR_W-1:0] RO_LIMIT  = 7'h08
) (
   input logic               clk,
   input logic               rst_n,
   input logic               csn_i,
   input logic               miso_en_o,
   input logic [WORD_AW-1:0] wr_addr_o,
   input logic [STRB_W-1:0]  wr_strb_o,
   input logic [REG_W-1:0]   wr_data_o
);
   localparam logic [WORD_AW-1:0] STAT_WORD = STAT_ADDR[ADDR_W-1:1];
   localparam logic [WORD_AW-1:0] RO_WORDS  = RO_LIMIT[ADDR_W-1:1];

   // R3
   cs_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csn_i |-> !miso_en_o);

   // R4
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_strb_o));

   // R4
   lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strb_o != '0) |-> (wr_data_o[REG_W-1:DATA_W] == wr_data_o[DATA_W-1:0]));

   // R8
   ro_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strb_o != '0) |-> ((wr_addr_o >= RO_WORDS) && (wr_addr_o != STAT_WORD)));
endmodule

bind spr_spi_regslave spr_spi_regslave_chk #(.STAT_ADDR(STAT_ADDR), .RO_LIMIT(RO_LIMIT)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .csn_i     (csn_i),
   .miso_en_o (miso_en_o),
   .wr_addr_o (wr_addr_o),
   .wr_strb_o (wr_strb_o),
   .wr_data_o (wr_data_o)
);

// File: tb/test_spr_spi_regslave.sv
`timescale 1ns/1ps
module test_spr_spi_regslave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        csn = 1'b1;
   logic        mosi = 1'b0;
   logic        miso_o, miso_en_o;
   logic [5:0]  rd_addr, wr_addr;
   logic [15:0] rd_data, wr_data;
   logic [1:0]  wr_strb;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [15:0] regs [64];
   int          wr_cnt = 0;
   logic [5:0]  last_addr = '0;
   logic [1:0]  last_strb = '0;
   logic [15:0] last_data = '0;

   always #2.5 clk = ~clk;

   spr_spi_regslave i_spr_spi_regslave (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk),
      .csn_i     (csn),
      .mosi_i    (mosi),
      .miso_o    (miso_o),
      .miso_en_o (miso_en_o),
      .rd_addr_o (rd_addr),
      .rd_data_i (rd_data),
      .wr_addr_o (wr_addr),
      .wr_strb_o (wr_strb),
      .wr_data_o (wr_data)
   );

   // register model: word i starts as {4i+2, 4(63-i)+1}
   assign rd_data = regs[rd_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) begin
            regs[i][15:8] = 8'(4 * i + 2);
            regs[i][7:0]  = 8'(4 * (63 - i) + 1);
         end
      end else if (wr_strb != 2'b00) begin
         if (wr_strb[0]) regs[wr_addr][7:0]  = wr_data[7:0];
         if (wr_strb[1]) regs[wr_addr][15:8] = wr_data[15:8];
         wr_cnt    = wr_cnt + 1;
         last_addr = wr_addr;
         last_strb = wr_strb;
         last_data = wr_data;
      end
   end

   // {frame sent, data expected back, enable expected}
   localparam int NV = 12;
   localparam logic [32:0] VEC [NV] = '{
      {16'h2200, 16'h0000, 1'b0},  // R10 no data after reset
      {16'h06FF, 16'h46B9, 1'b1},  // R2 word 0x11, R9 junk low bits
      {16'hA203, 16'h0EF1, 1'b1},  // R4 low byte write
      {16'hA3C7, 16'h0000, 1'b0},  // R3 after write: quiet
      {16'h2300, 16'h0000, 1'b0},  // R3 after write: quiet
      {16'h8655, 16'hC703, 1'b1},  // R4 merged bytes, R8 RO write
      {16'h0600, 16'h0000, 1'b0},
      {16'h2400, 16'h0EF1, 1'b1},  // R8 RO word unchanged
      {16'hAE12, 16'h4AB5, 1'b1},  // R8 status write
      {16'h2E00, 16'h0000, 1'b0},
      {16'h0000, 16'h0000, 1'b1},  // R10 status clear
      {16'h8000, 16'h02FD, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic shift_bits(input logic [15:0] din, input int n,
                             output logic [15:0] dout, output logic en_all, output logic en_any);
      dout = '0; en_all = 1'b1; en_any = 1'b0;
      for (int i = 15; i > 15 - n; i--) begin
         sclk = 1'b0; mosi = din[i];
         #35;
         dout[i] = miso_o;
         en_all  = en_all & miso_en_o;
         en_any  = en_any | miso_en_o;
         #5 sclk = 1'b1;
         #40;
      end
   endtask

   task automatic xfer(input logic [15:0] din, output logic [15:0] dout,
                       output logic en_all, output logic en_any);
      csn = 1'b0; #40;
      shift_bits(din, 16, dout, en_all, en_any);
      #40 csn = 1'b1; #80;
   endtask

   initial begin
      logic [15:0] d, d2;
      logic ea, en, ea2, en2;
      #50 rst_n = 1'b1;
      #20;
      chk("R10 enable after reset", miso_en_o, 1'b0);
      chk("R10 strobe after reset", wr_strb, 2'b00);

      for (int v = 0; v < NV; v++) begin
         xfer(VEC[v][32:17], d, ea, en);
         if (VEC[v][0]) begin
            chk($sformatf("R2 read data v%0d", v), d, VEC[v][16:1]);
            chk($sformatf("R3 enable held v%0d", v), ea, 1'b1);
         end else begin
            chk($sformatf("R3 enable quiet v%0d", v), en, 1'b0);
         end
         if (v == 2) begin
            chk("R1 write word addr", last_addr, 6'h11);
            chk("R4 even strobe", last_strb, 2'b01);
            chk("R4 write data", last_data, 16'h0303);
         end
         if (v == 3) begin
            chk("R4 odd strobe", last_strb, 2'b10);
            chk("R1 write byte", last_data, 16'hC7C7);
         end
         if (v == 5 || v == 8) chk("R8 discarded write", wr_cnt, 2);
      end

      // R6 short window of 5 clocks
      csn = 1'b0; #40;
      shift_bits(16'hFFFF, 5, d, ea, en);
      #40 csn = 1'b1; #80;
      chk("R3 quiet short window", en, 1'b0);
      xfer(16'h2E00, d, ea, en);
      xfer(16'h2E00, d, ea, en);
      chk("R6 status bit 3", d, 16'h0008);

      // R5 two frames in one window; first shows cleared status (R7)
      csn = 1'b0; #40;
      shift_bits(16'h2400, 16, d, ea, en);
      #40;
      shift_bits(16'h2200, 16, d2, ea2, en2);
      #40 csn = 1'b1; #80;
      chk("R7 status cleared by read", d, 16'h0000);
      chk("R5 second frame data", d2, 16'h4AB5);
      chk("R5 enable across frames", ea & ea2, 1'b1);
      chk("R3 enable low with cs high", miso_en_o, 1'b0);
      xfer(16'h8000, d, ea, en);
      chk("R2 data after pair", d, 16'hC703);
      xfer(16'h2E00, d, ea, en);
      xfer(16'h0000, d, ea, en);
      chk("R6 no flag for 32 edges", d, 16'h0000);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule